// File: doc/BRIEF.md
# Source-Routed Burst Crossbar

This block is a non-blocking switch that joins a set of ports, sixteen by default, and carries bursts of any length from each input to an output. A beat is 36 data bits, a tail flag and a 4-bit routing field. On the first beat of a burst the routing field names the destination output. On the way out the same field is overwritten with the number of the input that sent the burst, so the receiver can tell where the traffic came from.

Each output has its own round-robin arbiter. Once a burst has started through an output, that output stays with the same input until the tail beat has been accepted. Every port uses a valid/ready handshake. A stall at an output reaches back only to the input that currently holds that output. Pairs of ports that share no output move data in the same cycle without affecting each other. The datapath is combinational from input to output. The only state is the routing latch of each input and the lock and pointer of each output.

Top module: `burst_xbar`

## Requirements
- R1: A beat presented at input i whose burst is routed to output o appears on output o in the same cycle, with its 36 data bits and tail bit unchanged. The beats of one burst leave in the order in which they arrived.
- R2: Whenever output o is valid, its 4-bit `out_ctrl` holds the index of the input whose beat it is carrying.
- R3: The destination is taken from `in_ctrl` on the first beat only, meaning the beat after reset or after an accepted tail. On the remaining beats of the burst `in_ctrl` has no effect on routing.
- R4: After an output accepts a beat with tail 0, it carries only beats from that same input until a beat with tail 1 has been accepted. Other inputs that want this output are held with `in_ready` low.
- R5: An output that is not locked grants the requesting input nearest at or after its pointer, counting upward and wrapping. The pointer starts at 0 after reset and moves to the winner's index plus one, modulo the port count, when the winner's tail beat is accepted.
- R6: `in_ready` of input i is high only while i holds a grant at its destination output and that output's `out_ready` is high. A stalled output stalls only its owner, and unrelated input/output pairs transfer in the same cycle.
- R7: A burst of one beat, whose first beat carries tail 1, releases the output in the cycle in which it is accepted. A different input can win that output on the very next cycle.
- R8: While reset is held and immediately after it, no output is valid, no output is locked, and `in_ready` is low on every idle input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORT | Beat present at each input |
| in_data | input | NPORT x DATA_W | Data bits of each input beat |
| in_tail | input | NPORT | Last-beat flag of each input beat |
| in_ctrl | input | NPORT x CTRL_W | Destination output, read on the first beat |
| in_ready | output | NPORT | Input beat accepted this cycle when high together with valid |
| out_valid | output | NPORT | Beat present at each output |
| out_data | output | NPORT x DATA_W | Data bits of each output beat |
| out_tail | output | NPORT | Last-beat flag of each output beat |
| out_ctrl | output | NPORT x CTRL_W | Index of the input that sent the beat |
| out_ready | input | NPORT | Output sink can take a beat |

## Verification
The crossbar is driven with several traffic patterns.

- **Changing routing field:** a lone multi-beat burst whose routing field changes on its later beats. This separates a latched destination from one that is decoded on every beat.
- **Simultaneous one-beat bursts:** several one-beat bursts aimed at the same output in the same cycle. The order and the cycles in which they come out expose the round-robin pointer and the release on a tail-only beat.
- **Competing long bursts with random stalls:** two long bursts competing for one output under random `out_ready` stalls. Any interleaving there shows that the lock was lost.
- **Held output beside a free pair:** one output is held stalled while an unrelated pair keeps running, which tells a local stall apart from a global one.
- **Random traffic:** a long stretch of random traffic is compared every cycle with a behavioural model on every port.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic {ARB_OPEN, ARB_HELD} arb_state_e;

  // Next index after cur, wrapping at n.
  function automatic int rr_next(int cur, int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // Distance from the round-robin pointer to idx, counting upward with wrap.
  function automatic int rr_dist(int idx, int ptr, int n);
    return (idx >= ptr) ? (idx - ptr) : (idx + n - ptr);
  endfunction

endpackage

// File: rtl/xbar_route_track.sv
module xbar_route_track #(
  parameter int NPORT  = 16,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_tail,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic [NPORT-1:0]  gnt_row,
  input  logic [NPORT-1:0]  out_ready,
  output logic              in_ready,
  output logic [NPORT-1:0]  req
);

  logic              busy_q;
  logic [CTRL_W-1:0] dest_q;
  logic [CTRL_W-1:0] dest_eff;
  logic              take;

  // The first beat decodes in_ctrl; later beats reuse the latched destination.
  assign dest_eff = busy_q ? dest_q : in_ctrl;

  always_comb begin
    in_ready = 1'b0;
    for (int o = 0; o < NPORT; o++) begin
      req[o] = in_valid && (dest_eff == CTRL_W'(o));
      if (dest_eff == CTRL_W'(o)) in_ready = gnt_row[o] && out_ready[o];
    end
  end

  assign take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dest_q <= '0;
    end else if (take) begin
      busy_q <= !in_tail;
      dest_q <= dest_eff;
    end
  end

endmodule

// File: rtl/xbar_out_port.sv
module xbar_out_port
  import xbar_pkg::*;
#(
  parameter int NPORT  = 16,
  parameter int DATA_W = 36,
  parameter int CTRL_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              req,
  input  logic [NPORT-1:0]              in_valid,
  input  logic [NPORT-1:0][DATA_W-1:0]  in_data,
  input  logic [NPORT-1:0]              in_tail,
  input  logic                          out_ready,
  output logic                          out_valid,
  output logic [DATA_W-1:0]             out_data,
  output logic                          out_tail,
  output logic [CTRL_W-1:0]             out_ctrl,
  output logic [NPORT-1:0]              gnt,
  output logic                          held,
  output logic                          accept,
  output logic                          release_ev
);

  localparam int NO_PICK = NPORT;

  arb_state_e        state_q;
  logic [CTRL_W-1:0] owner_q;
  logic [CTRL_W-1:0] ptr_q;
  logic [CTRL_W-1:0] pick_idx;
  logic [CTRL_W-1:0] sel;
  logic              found;
  logic              live;

  // Round-robin search: the requester closest at or after the pointer.
  always_comb begin
    int best_d;
    best_d   = NO_PICK;
    pick_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (req[i] && (rr_dist(i, int'(ptr_q), NPORT) < best_d)) begin
        best_d   = rr_dist(i, int'(ptr_q), NPORT);
        pick_idx = CTRL_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign held      = (state_q == ARB_HELD);
  assign sel       = held ? owner_q : pick_idx;
  assign live      = held || found;
  assign out_valid = live && in_valid[sel];
  assign out_data  = in_data[sel];
  assign out_tail  = in_tail[sel];
  assign out_ctrl  = sel;

  always_comb begin
    for (int i = 0; i < NPORT; i++) gnt[i] = live && (sel == CTRL_W'(i));
  end

  assign accept     = out_valid && out_ready;
  assign release_ev = accept && out_tail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ARB_OPEN;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (accept) begin
      if (out_tail) begin
        state_q <= ARB_OPEN;
        ptr_q   <= CTRL_W'(rr_next(int'(sel), NPORT));
      end else begin
        state_q <= ARB_HELD;
        owner_q <= sel;
      end
    end
  end

endmodule

// File: rtl/burst_xbar.sv
module burst_xbar #(
  parameter int NPORT  = 16,
  parameter int DATA_W = 36,
  parameter int CTRL_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              in_valid,
  input  logic [NPORT-1:0][DATA_W-1:0]  in_data,
  input  logic [NPORT-1:0]              in_tail,
  input  logic [NPORT-1:0][CTRL_W-1:0]  in_ctrl,
  output logic [NPORT-1:0]              in_ready,
  output logic [NPORT-1:0]              out_valid,
  output logic [NPORT-1:0][DATA_W-1:0]  out_data,
  output logic [NPORT-1:0]              out_tail,
  output logic [NPORT-1:0][CTRL_W-1:0]  out_ctrl,
  input  logic [NPORT-1:0]              out_ready
);

  // Named internal events, brought out for the bound checker.
  logic [NPORT-1:0][NPORT-1:0] req_mat;   // [input][output]
  logic [NPORT-1:0][NPORT-1:0] req_col;   // [output][input]
  logic [NPORT-1:0][NPORT-1:0] gnt_mat;   // [output][input]
  logic [NPORT-1:0][NPORT-1:0] gnt_row;   // [input][output]
  logic [NPORT-1:0]            arb_held;
  logic [NPORT-1:0]            beat_accept;
  logic [NPORT-1:0]            burst_release;

  for (genvar a = 0; a < NPORT; a++) begin : g_xpose
    for (genvar b = 0; b < NPORT; b++) begin : g_cell
      assign req_col[b][a] = req_mat[a][b];
      assign gnt_row[a][b] = gnt_mat[b][a];
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    xbar_route_track #(.NPORT(NPORT), .CTRL_W(CTRL_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid[i]),
      .in_tail   (in_tail[i]),
      .in_ctrl   (in_ctrl[i]),
      .gnt_row   (gnt_row[i]),
      .out_ready (out_ready),
      .in_ready  (in_ready[i]),
      .req       (req_mat[i])
    );
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    xbar_out_port #(.NPORT(NPORT), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req_col[o]),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_tail    (in_tail),
      .out_ready  (out_ready[o]),
      .out_valid  (out_valid[o]),
      .out_data   (out_data[o]),
      .out_tail   (out_tail[o]),
      .out_ctrl   (out_ctrl[o]),
      .gnt        (gnt_mat[o]),
      .held       (arb_held[o]),
      .accept     (beat_accept[o]),
      .release_ev (burst_release[o])
    );
  end

endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
  parameter int NPORT  = 16,
  parameter int CTRL_W = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NPORT-1:0]              in_valid,
  input logic [NPORT-1:0]              in_ready,
  input logic [NPORT-1:0]              out_valid,
  input logic [NPORT-1:0]              out_ready,
  input logic [NPORT-1:0]              out_tail,
  input logic [NPORT-1:0][CTRL_W-1:0]  out_ctrl,
  input logic [NPORT-1:0][NPORT-1:0]   gnt_mat,
  input logic [NPORT-1:0]              arb_held,
  input logic [NPORT-1:0]              beat_accept,
  input logic [NPORT-1:0]              burst_release
);

  // acc_from[i][o]: output o takes a beat from input i this cycle.
  logic [NPORT-1:0][NPORT-1:0] acc_from;
  always_comb begin
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        acc_from[i][o] = out_valid[o] && out_ready[o] && (out_ctrl[o] == CTRL_W'(i));
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    p_src_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> in_valid[out_ctrl[o]]);
    p_hold_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_accept[o] && !out_tail[o]) |=> (arb_held[o] && out_ctrl[o] == $past(out_ctrl[o])));
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      burst_release[o] |=> !arb_held[o]);
    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_mat[o]));
    p_stall_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |-> !in_ready[out_ctrl[o]]);
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    p_conserve_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[i] && in_ready[i]) == ($countones(acc_from[i]) == 1));
    p_idle_after_reset_r8: assert property (@(posedge clk)
      !rst_n |=> !arb_held[i]);
  end

endmodule

bind burst_xbar xbar_checker #(.NPORT(NPORT), .CTRL_W(CTRL_W)) u_xbar_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_tail      (out_tail),
  .out_ctrl      (out_ctrl),
  .gnt_mat       (gnt_mat),
  .arb_held      (arb_held),
  .beat_accept   (beat_accept),
  .burst_release (burst_release)
);

// File: tb/test_burst_xbar.sv
module test_burst_xbar;
  localparam int NP = 16;
  localparam int DW = 36;
  localparam int CW = 4;
  localparam int BW = DW + 1 + CW;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP-1:0]         in_valid, in_tail, in_ready, out_valid, out_tail, out_ready;
  logic [NP-1:0][DW-1:0] in_data, out_data;
  logic [NP-1:0][CW-1:0] in_ctrl, out_ctrl;

  burst_xbar #(.NPORT(NP), .DATA_W(DW), .CTRL_W(CW)) i_burst_xbar (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_tail(in_tail), .in_ctrl(in_ctrl),
    .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_tail(out_tail), .out_ctrl(out_ctrl),
    .out_ready(out_ready)
  );

  logic [BW-1:0] q [NP][$];
  int            log_src [NP][$];
  int            log_cyc [NP][$];
  int errors = 0;
  int checks = 0;
  int cycle  = 0;
  bit rand_ready = 1'b0;
  logic [NP-1:0] rdy_set = '1;

  // Behavioural reference state.
  int m_busy [NP];
  int m_dest [NP];
  int m_held [NP];
  int m_own  [NP];
  int m_ptr  [NP];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cycle);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Beat data: source in bits 35:28, burst id in 27:12, beat number in 11:0.
  task automatic push_burst(int src, int dst, int len, int id, int later_ctrl);
    for (int b = 0; b < len; b++) begin
      logic [DW-1:0] d;
      logic [CW-1:0] c;
      d = {src[7:0], id[15:0], b[11:0]};
      if (b == 0) c = CW'(dst);
      else if (later_ctrl >= 0) c = CW'(later_ctrl);
      else c = CW'($urandom_range(0, NP-1));
      q[src].push_back({c, (b == len-1), d});
    end
  endtask

  function automatic bit queues_empty();
    for (int i = 0; i < NP; i++) if (q[i].size() != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic clear_logs();
    for (int o = 0; o < NP; o++) begin
      log_src[o].delete();
      log_cyc[o].delete();
    end
  endtask

  task automatic drain();
    while (!queues_empty()) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  always @(posedge clk) begin
    cycle++;
    if (cycle > WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cycle, WD_LIMIT);
      summary();
      $finish;
    end
  end

  // Driver, reference model and per-cycle comparison.
  initial begin
    in_valid = '0; in_tail = '0; in_data = '0; in_ctrl = '0; out_ready = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        in_valid = '0;
        out_ready = '0;
        for (int i = 0; i < NP; i++) begin
          m_busy[i] = 0; m_dest[i] = 0; m_held[i] = 0; m_own[i] = 0; m_ptr[i] = 0;
        end
        continue;
      end
      for (int i = 0; i < NP; i++) begin
        if (q[i].size() != 0) begin
          {in_ctrl[i], in_tail[i], in_data[i]} = q[i][0];
          in_valid[i] = 1'b1;
        end else begin
          in_valid[i] = 1'b0;
        end
      end
      out_ready = rand_ready ? NP'($urandom) : rdy_set;
      #1;
      begin
        int  deff [NP];
        int  sel  [NP];
        bit  live [NP];
        bit  e_ov [NP];
        bit  e_rdy [NP];
        for (int i = 0; i < NP; i++) deff[i] = m_busy[i] ? m_dest[i] : int'(in_ctrl[i]);
        for (int o = 0; o < NP; o++) begin
          live[o] = 1'b0; sel[o] = 0;
          if (m_held[o] != 0) begin
            live[o] = 1'b1; sel[o] = m_own[o];
          end else begin
            for (int k = 0; k < NP; k++) begin
              int idx;
              idx = (m_ptr[o] + k) % NP;
              if (!live[o] && in_valid[idx] && deff[idx] == o) begin
                live[o] = 1'b1; sel[o] = idx;
              end
            end
          end
          e_ov[o] = live[o] && in_valid[sel[o]];
        end
        for (int i = 0; i < NP; i++)
          e_rdy[i] = live[deff[i]] && sel[deff[i]] == i && out_ready[deff[i]];
        for (int o = 0; o < NP; o++) begin
          check(out_valid[o] == e_ov[o], "R1", $sformatf("out_valid[%0d]", o), out_valid[o], e_ov[o]);
          if (e_ov[o]) begin
            check(out_ctrl[o] == CW'(sel[o]), "R2", $sformatf("out_ctrl[%0d]", o), out_ctrl[o], sel[o]);
            check(out_data[o] == in_data[sel[o]], "R1", $sformatf("out_data[%0d]", o),
                  out_data[o], in_data[sel[o]]);
            check(out_tail[o] == in_tail[sel[o]], "R1", $sformatf("out_tail[%0d]", o),
                  out_tail[o], in_tail[sel[o]]);
          end
        end
        for (int i = 0; i < NP; i++)
          check(in_ready[i] == e_rdy[i], "R6", $sformatf("in_ready[%0d]", i), in_ready[i], e_rdy[i]);
        // Advance the model with the expected handshakes.
        for (int o = 0; o < NP; o++) begin
          if (e_ov[o] && out_ready[o]) begin
            if (in_tail[sel[o]]) begin
              m_held[o] = 0; m_ptr[o] = (sel[o] + 1) % NP;
            end else begin
              m_held[o] = 1; m_own[o] = sel[o];
            end
          end
          if (out_valid[o] && out_ready[o]) begin
            log_src[o].push_back(int'(out_ctrl[o]));
            log_cyc[o].push_back(cycle);
          end
        end
        for (int i = 0; i < NP; i++) begin
          if (in_valid[i] && e_rdy[i]) begin
            m_busy[i] = in_tail[i] ? 0 : 1;
            m_dest[i] = deff[i];
          end
          if (in_valid[i] && in_ready[i]) void'(q[i].pop_front());
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R8: nothing valid or ready while reset is held.
    #1;
    check(out_valid == '0, "R8", "out_valid in reset", out_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #2;
    check(out_valid == '0, "R8", "out_valid after reset", out_valid, 0);
    check(in_ready == '0, "R8", "in_ready after reset", in_ready, 0);
    @(posedge clk);

    // R3: later beats carry routing field 9, but the burst stays on output 5.
    clear_logs();
    push_burst(3, 5, 3, 1, 9);
    drain();
    check(log_src[5].size() == 3, "R3", "beats on output 5", log_src[5].size(), 3);
    check(log_src[9].size() == 0, "R3", "beats on output 9", log_src[9].size(), 0);
    if (log_src[5].size() == 3)
      check(log_src[5][2] == 3, "R2", "source tag of last beat", log_src[5][2], 3);

    // R5/R7: one-beat bursts from 7, 2, 1 to output 0, pointer at 0.
    clear_logs();
    push_burst(7, 0, 1, 2, -1);
    push_burst(2, 0, 1, 3, -1);
    push_burst(1, 0, 1, 4, -1);
    drain();
    check(log_src[0].size() == 3, "R5", "grants on output 0", log_src[0].size(), 3);
    if (log_src[0].size() == 3) begin
      check(log_src[0][0] == 1, "R5", "first winner", log_src[0][0], 1);
      check(log_src[0][1] == 2, "R5", "second winner", log_src[0][1], 2);
      check(log_src[0][2] == 7, "R5", "third winner", log_src[0][2], 7);
      check(log_cyc[0][2] - log_cyc[0][0] == 2, "R7", "back-to-back one-beat grants",
            log_cyc[0][2] - log_cyc[0][0], 2);
    end
    // Pointer now at 8: input 9 must beat input 1.
    clear_logs();
    push_burst(1, 0, 1, 5, -1);
    push_burst(9, 0, 1, 6, -1);
    drain();
    if (log_src[0].size() == 2) begin
      check(log_src[0][0] == 9, "R5", "winner after wrap pointer", log_src[0][0], 9);
      check(log_src[0][1] == 1, "R5", "second after wrap pointer", log_src[0][1], 1);
    end else check(1'b0, "R5", "grants after wrap", log_src[0].size(), 2);

    // R4: input 4 (4 beats) and input 6 (2 beats) contend for output 2 under random stalls.
    clear_logs();
    rand_ready = 1'b1;
    push_burst(4, 2, 4, 7, -1);
    push_burst(6, 2, 2, 8, -1);
    drain();
    rand_ready = 1'b0;
    check(log_src[2].size() == 6, "R4", "beats on output 2", log_src[2].size(), 6);
    if (log_src[2].size() == 6)
      for (int k = 0; k < 6; k++)
        check(log_src[2][k] == ((k < 4) ? 4 : 6), "R4", $sformatf("burst lock beat %0d", k),
              log_src[2][k], (k < 4) ? 4 : 6);

    // R6: output 2 stalled; pair 8 -> 3 must still flow.
    clear_logs();
    rdy_set = '1;
    rdy_set[2] = 1'b0;
    push_burst(4, 2, 2, 9, -1);
    push_burst(8, 3, 3, 10, -1);
    repeat (10) @(posedge clk);
    check(log_src[2].size() == 0, "R6", "beats on stalled output", log_src[2].size(), 0);
    check(log_src[3].size() == 3, "R6", "beats on independent output", log_src[3].size(), 3);
    check(q[4].size() == 2, "R6", "beats left at stalled input", q[4].size(), 2);
    rdy_set = '1;
    drain();
    check(log_src[2].size() == 2, "R6", "beats after stall lifted", log_src[2].size(), 2);

    // Random traffic, compared every cycle against the model (R1, R2, R6).
    rand_ready = 1'b1;
    for (int n = 0; n < 400; n++) begin
      int s;
      s = $urandom_range(0, NP-1);
      if (q[s].size() < 8)
        push_burst(s, $urandom_range(0, NP-1), $urandom_range(1, 5), 100 + n, -1);
      @(posedge clk);
    end
    drain();
    rand_ready = 1'b0;

    summary();
    $finish;
  end

endmodule